// File: doc/BRIEF.md
# Sampled Saturating-Counter Debouncer

This block cleans up contact bounce on a group of push-button levels that have already been brought into the local clock domain. A single divider, shared by every channel, produces a one-cycle sample tick at a fixed period. Each channel keeps its own saturating counter. The counter steps up by one on a sample tick while its input is high, and it returns to zero on any cycle where the input is low. The clean level of a channel is high only while its counter sits at the ceiling. A short high stretch therefore never gets through, and a steady press is reported until the button is released.

Alongside each clean level, the block gives a one-cycle pulse when that level goes from 0 to 1, so downstream logic can count presses without its own edge detector. The block has no data stream, so every pin is a plain level or pulse with no valid/ready handshake. Reset is synchronous and active high. Setting the divider period and the ceiling fixes the debounce time: a channel must stay high for between (PULSE_COUNT_MAX-1)*SAMPLE_COUNT_MAX+1 and PULSE_COUNT_MAX*SAMPLE_COUNT_MAX cycles before its level rises.

Top module: `sampled_debouncer`

## Requirements
- R1: The shared sample tick fires once every SAMPLE_COUNT_MAX clock cycles. The first tick falls on the SAMPLE_COUNT_MAX-th rising edge after reset is released.
- R2: Every channel has its own counter and they all use the same tick. Activity on one channel never changes the level or pulse of another channel.
- R3: A channel counter steps up by one only on an edge where the tick and that channel's input are both high. An input held high through and after reset therefore raises `clean_lvl` right after the PULSE_COUNT_MAX*SAMPLE_COUNT_MAX-th edge following reset release, and not one edge earlier.
- R4: On any edge where a channel input is 0, that channel's counter returns to 0 whether or not a tick is present. Its `clean_lvl` is 0 right after that edge, and counting starts over from zero when the input rises again.
- R5: Once a counter reaches PULSE_COUNT_MAX it stays there while the input remains high, so `clean_lvl` stays 1 until the input falls.
- R6: `clean_lvl[i]` is 1 exactly when counter i equals PULSE_COUNT_MAX. An input that bounces and then stays high for no more than (PULSE_COUNT_MAX-1)*SAMPLE_COUNT_MAX cycles never raises it.
- R7: `press_pulse[i]` is high for exactly one cycle: the first cycle in which `clean_lvl[i]` is 1 after being 0. A level held high produces no further pulse.
- R8: A synchronous reset clears the divider and every counter. While reset is held, and in the cycle after it, `clean_lvl` and `press_pulse` are all 0. The timing of R3 restarts from the release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_sync | input | WIDTH | Synchronized, still bouncy button levels, one bit per channel |
| clean_lvl | output | WIDTH | Debounced level per channel |
| press_pulse | output | WIDTH | One-cycle pulse per channel on each 0-to-1 step of `clean_lvl` |

## Verification
The hardest case to reach from the ports is the exact edge on which a level rises. The phase of the shared tick cannot be seen from the outside, so the bench fixes it by holding the inputs high through reset and counting edges from the release. It then samples one edge before and on the predicted edge. In scenarios where the tick phase is unknown, such as re-pressing after a release, bouncing, or a reset partway through a count, the bench checks cycle by cycle against the window bounds instead. A high stretch of (PULSE_COUNT_MAX-1)*SAMPLE_COUNT_MAX cycles must never reach the ceiling, and one of PULSE_COUNT_MAX*SAMPLE_COUNT_MAX cycles always must.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  // Bits needed to hold values 0..max_val (at least one bit).
  function automatic int bits_for(input int max_val);
    int b;
    b = $clog2(max_val + 1);
    return (b < 1) ? 1 : b;
  endfunction
endpackage

// File: rtl/dbnc_tick_gen.sv
module dbnc_tick_gen #(
  parameter int SAMPLE_COUNT_MAX = 25000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int TW = dbnc_pkg::bits_for(SAMPLE_COUNT_MAX - 1);
  localparam logic [TW-1:0] LAST = TW'(SAMPLE_COUNT_MAX - 1);

  logic [TW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)               div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + TW'(1);
  end

  assign tick = (div_q == LAST);

  // R1
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    div_q <= LAST);

  generate
    if (SAMPLE_COUNT_MAX > 1) begin : g_spaced
      // R1
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dbnc_channel.sv
module dbnc_channel #(
  parameter int PULSE_COUNT_MAX = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic level
);
  localparam int CW = dbnc_pkg::bits_for(PULSE_COUNT_MAX);
  localparam logic [CW-1:0] CEIL = CW'(PULSE_COUNT_MAX);

  logic [CW-1:0] sat_q;

  always_ff @(posedge clk) begin
    if (rst || !din)                  sat_q <= '0;
    else if (tick && (sat_q != CEIL)) sat_q <= sat_q + CW'(1);
  end

  assign level = (sat_q == CEIL);

  // R4
  clear_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    !din |=> (sat_q == '0));

  // R3
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (din && !tick) |=> $stable(sat_q));

  // R3
  step_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (din && tick && (sat_q != CEIL)) |=> (sat_q == $past(sat_q) + CW'(1)));

  // R5
  saturate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (level && din) |=> level);
endmodule

// File: rtl/dbnc_rise_pulse.sv
module dbnc_rise_pulse (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign pulse = lvl && !prev_q;

  // R7
  single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R7
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lvl) |-> pulse);
endmodule

// File: rtl/sampled_debouncer.sv
module sampled_debouncer #(
  parameter int WIDTH            = 4,
  parameter int SAMPLE_COUNT_MAX = 25000,
  parameter int PULSE_COUNT_MAX  = 150
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] btn_sync,
  output logic [WIDTH-1:0] clean_lvl,
  output logic [WIDTH-1:0] press_pulse
);
  logic tick;

  dbnc_tick_gen #(.SAMPLE_COUNT_MAX(SAMPLE_COUNT_MAX)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  generate
    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_ch
      dbnc_channel #(.PULSE_COUNT_MAX(PULSE_COUNT_MAX)) u_chan (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .din   (btn_sync[ch]),
        .level (clean_lvl[ch])
      );
      dbnc_rise_pulse u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl   (clean_lvl[ch]),
        .pulse (press_pulse[ch])
      );
    end
  endgenerate

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (clean_lvl == '0) && (press_pulse == '0));

  // R7
  pulse_implies_level_chk: assert property (@(posedge clk) disable iff (rst)
    (press_pulse & ~clean_lvl) == '0);
endmodule

// File: tb/sampled_debouncer_tb.sv
`timescale 1ns/1ps
module sampled_debouncer_tb;
  localparam int W  = 3;
  localparam int SM = 4;
  localparam int PM = 3;
  localparam int FULL  = PM * SM;        // 12
  localparam int SHORT = (PM - 1) * SM;  // 8

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] btn = '0;
  logic [W-1:0] lvl;
  logic [W-1:0] pls;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sampled_debouncer #(.WIDTH(W), .SAMPLE_COUNT_MAX(SM), .PULSE_COUNT_MAX(PM)) u_dut (
    .clk(clk), .rst(rst), .btn_sync(btn), .clean_lvl(lvl), .press_pulse(pls)
  );

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [W-1:0] v);
    btn = v; rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  // R8: outputs quiet under and right after reset
  task automatic t_reset();
    btn = '1; rst = 1'b1;
    step(3);
    chk("R8 lvl in reset", lvl, '0);
    chk("R8 pulse in reset", pls, '0);
    rst = 1'b0;
    step(1);
    chk("R8 lvl after release", lvl, '0);
  endtask

  // R1 R3 R5 R7: exact rise edge with inputs held high from reset
  task automatic t_exact_rise();
    do_reset('1);
    step(FULL - 1);
    chk("R3 one edge early", lvl, '0);
    step(1);
    chk("R3 on predicted edge", lvl, '1);
    chk("R7 pulse on rise", pls, '1);
    step(1);
    chk("R7 pulse one cycle", pls, '0);
    step(10);
    chk("R5 held at ceiling", lvl, '1);
    chk("R7 no repeat pulse", pls, '0);
  endtask

  // R6: bounce then short high never rises
  task automatic t_short_high();
    logic [W-1:0] bad;
    bad = '0;
    do_reset('0);
    btn = '1; step(1); btn = '0; step(1); btn = '1; step(2); btn = '0; step(1);
    btn = '1;
    for (int i = 0; i < SHORT; i++) begin
      step(1);
      bad = bad | lvl | pls;
    end
    btn = '0; step(2);
    bad = bad | lvl;
    chk("R6 short high stays low", bad, '0);
  endtask

  // R4: low clears immediately and counting restarts
  task automatic t_clear_on_low();
    logic [W-1:0] bad;
    bad = '0;
    do_reset('1);
    step(FULL);
    chk("R4 setup saturated", lvl, '1);
    btn = '0; step(1);
    chk("R4 low clears at once", lvl, '0);
    btn = '1;
    for (int i = 0; i < SHORT; i++) begin
      step(1);
      bad = bad | lvl;
    end
    chk("R4 restart from zero", bad, '0);
    step(FULL - SHORT);
    chk("R4 rises again", lvl, '1);
  endtask

  // R2: channels do not disturb one another
  task automatic t_independent();
    int rises;
    logic [W-1:0] other;
    rises = 0; other = '0;
    do_reset('0);
    for (int i = 0; i < FULL + 4; i++) begin
      btn = {1'b0, i[0], 1'b1};
      step(1);
      if (pls[0]) rises++;
      other = other | (lvl & 3'b110) | (pls & 3'b110);
    end
    chk("R2 ch0 clean", lvl, 3'b001);
    chk("R2 others untouched", other, '0);
    checks++;
    if (rises != 1) begin
      errors++;
      $display("FAIL R7 ch0 pulses actual=%0d expected=1", rises);
    end
  endtask

  // R7 R5: long bounce then hold gives one pulse
  task automatic t_long_hold();
    int rises;
    rises = 0;
    do_reset('0);
    btn = 3'b010; step(1); btn = '0; step(1); btn = 3'b010; step(1); btn = '0; step(1);
    btn = 3'b010;
    for (int i = 0; i < FULL + 10; i++) begin
      step(1);
      if (pls[1]) rises++;
    end
    chk("R5 long hold high", lvl, 3'b010);
    checks++;
    if (rises != 1) begin
      errors++;
      $display("FAIL R7 pulses in hold actual=%0d expected=1", rises);
    end
    btn = '0; step(1);
    chk("R4 release drops", lvl, '0);
  endtask

  // R8: reset partway through a count restarts the timing
  task automatic t_reset_midway();
    do_reset('1);
    step(7);
    rst = 1'b1; step(1);
    chk("R8 mid reset clears", lvl, '0);
    rst = 1'b0;
    step(FULL - 1);
    chk("R8 retimed early", lvl, '0);
    step(1);
    chk("R8 retimed rise", lvl, '1);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_exact_rise();
    t_short_high();
    t_clear_on_low();
    t_independent();
    t_long_hold();
    t_reset_midway();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule